// File: doc/BRIEF.md
# Self-Timed Erase and Program Sequencer

This block sits behind the command decoder of a serial flash model. When the decoder has taken in a complete, valid write frame and chip select has gone inactive, it sends a single-cycle start pulse. The pulse carries the operation kind, a byte address and a data byte. The sequencer then runs the operation on a behavioural byte array built from equal-size sectors. A sector erase fills one sector with FFh. A chip erase fills the whole array with FFh. A byte program can only clear bits of one byte.

Each operation is timed by a down-counter loaded from a duration parameter given in system-clock cycles. While the counter runs the block reports busy, and the decoder builds status bit 0 from the ready output. The array is changed in one step on the last cycle of the interval. The write-protect input, when low, blocks new requests. The active-low reset cancels a running operation and leaves the array as it was. A registered read port lets the decoder stream bytes out of the array.

Top module: `flash_write_seq`

## Requirements
- R1: While rst_n is low and after it is released, busy is 0 and ready is 1 until a request is accepted.
- R2: Operation code 2'b01 (sector erase) sets every byte of the sector that contains req_addr to FFh. The sector is selected by the address bits above log2(SECTOR_BYTES). Bytes in other sectors keep their value.
- R3: Operation code 2'b10 (chip erase) sets every byte of the array to FFh and ignores req_addr.
- R4: Operation code 2'b11 (byte program) stores the bitwise AND of the old byte at req_addr and req_data, so a byte that is not erased can only lose 1-bits.
- R5: A request is accepted on a clock edge where req_valid is 1, wp_n is 1, busy is 0 and the code is not 2'b00. busy is then 1 for exactly T_SECTOR, T_CHIP or T_BYTE cycles, starting with the cycle after acceptance. ready is always the inverse of busy.
- R6: The array does not change while busy is 1. The update takes effect on the edge where busy falls, and a read sampled on that same edge still returns the old value.
- R7: A request presented while wp_n is 0 is ignored. busy stays 0 and the array is unchanged.
- R8: A request presented while busy is 1 is ignored. The running operation finishes with its own address and data, and the ignored request leaves no trace.
- R9: rst_n going low drops busy at once and cancels the running operation, which leaves the affected bytes untouched. Requests are ignored while rst_n is low.
- R10: rd_data returns the array byte at rd_addr as sampled on the previous clock edge (one-cycle latency).
- R11: Operation code 2'b00 is not an operation. A pulse carrying it leaves busy at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; cancels a running operation |
| wp_n | input | 1 | Write enable from the protect pin; low blocks requests |
| req_valid | input | 1 | Single-cycle start pulse from the command decoder |
| req_op | input | 2 | Operation code: 01 sector erase, 10 chip erase, 11 program, 00 none |
| req_addr | input | AW | Byte address of the request |
| req_data | input | 8 | Data byte for a program |
| rd_addr | input | AW | Read port address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | A timed operation is running |
| ready | output | 1 | Inverse of busy, for status bit 0 |

## Verification
The bench builds the sequencer with four sectors of sixteen bytes, 64 bytes in all. With so few bytes it can check whole sectors and sector boundaries directly, and a reference array in the bench can mirror every byte. The three durations are shortened to 12, 20 and 5 cycles. At those lengths the exact busy window, requests landing in the middle of an operation, and a reset that cuts an operation short are all reached within a few hundred cycles. Default parameters keep real 4 KB-style timing in cycles, but they are only elaborated, not run.

// File: rtl/flash_write_seq.sv
module flash_write_seq #(
  parameter int NUM_SECTORS  = 16,
  parameter int SECTOR_BYTES = 64,
  parameter int T_SECTOR     = 1800000,
  parameter int T_CHIP       = 7000000,
  parameter int T_BYTE       = 1400,
  localparam int DEPTH = NUM_SECTORS * SECTOR_BYTES,
  localparam int AW    = $clog2(DEPTH),
  localparam int OW    = $clog2(SECTOR_BYTES),
  localparam int TMAX  = (T_CHIP > T_SECTOR) ? ((T_CHIP > T_BYTE) ? T_CHIP : T_BYTE)
                                             : ((T_SECTOR > T_BYTE) ? T_SECTOR : T_BYTE),
  localparam int CW    = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          ready
);
  localparam logic [1:0] OP_NONE = 2'b00;
  localparam logic [1:0] OP_SECT = 2'b01;
  localparam logic [1:0] OP_CHIP = 2'b10;
  localparam logic [1:0] OP_PROG = 2'b11;

  logic [7:0]    mem [DEPTH];
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] dur;

  wire accept = req_valid && wp_n && !busy && (req_op != OP_NONE);
  wire done   = busy && (cnt == '0);

  assign ready = ~busy;

  always_comb begin
    case (req_op)
      OP_SECT: dur = CW'(T_SECTOR);
      OP_CHIP: dur = CW'(T_CHIP);
      default: dur = CW'(T_BYTE);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      op_q   <= OP_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= dur - CW'(1);
      op_q   <= req_op;
      addr_q <= req_addr;
      data_q <= req_data;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
    if (done) begin
      if (op_q == OP_PROG) begin
        mem[addr_q] <= mem[addr_q] & data_q;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (op_q == OP_CHIP || ((AW'(i) >> OW) == (addr_q >> OW)))
            mem[i] <= 8'hFF;
        end
      end
    end
  end

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - CW'(1)));
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_wp_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wp_n) |=> !busy);
  p_none_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_op == OP_NONE) |=> !busy);
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));

  always @(posedge clk) begin
    if (!rst_n) p_reset_idle_r9: assert (!busy && ready);
  end
endmodule

// File: tb/flash_write_seq_tb_top.sv
module flash_write_seq_tb_top;
  localparam int NS = 4, SB = 16, DEPTH = NS * SB, AW = 6;
  localparam int TS = 12, TC = 20, TB = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0, wp_n = 1'b1, req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [AW-1:0] req_addr = '0, rd_addr = '0;
  logic [7:0] req_data = '0;
  logic [7:0] rd_data;
  logic busy, ready;

  int tests = 0, fails = 0, cyc = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  flash_write_seq #(.NUM_SECTORS(NS), .SECTOR_BYTES(SB), .T_SECTOR(TS),
                    .T_CHIP(TC), .T_BYTE(TB)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .ready(ready));

  // reference model
  logic [7:0] m_mem [DEPTH];
  bit         m_known [DEPTH];
  bit         m_busy = 0;
  int         m_rem = 0, m_op = 0, m_addr = 0;
  logic [7:0] m_data = 0, m_rd = 0;
  bit         m_rd_ok = 0;

  function automatic int dur_of(input int op);
    return (op == 1) ? TS : (op == 2) ? TC : TB;
  endfunction

  always @(posedge clk) begin
    m_rd    = m_mem[rd_addr];
    m_rd_ok = m_known[rd_addr];
    if (!rst_n) m_busy = 0;
    else if (m_busy) begin
      if (m_rem == 1) begin
        m_busy = 0;
        if (m_op == 3) m_mem[m_addr] = m_mem[m_addr] & m_data;
        else for (int i = 0; i < DEPTH; i++)
          if (m_op == 2 || (i / SB) == (m_addr / SB)) begin m_mem[i] = 8'hFF; m_known[i] = 1; end
      end else m_rem--;
    end else if (req_valid && wp_n && req_op != 2'b00) begin
      m_busy = 1; m_op = int'(req_op); m_rem = dur_of(m_op);
      m_addr = int'(req_addr); m_data = req_data;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string r);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", r, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    #1;
    chk({7'd0, busy}, {7'd0, m_busy && rst_n}, {"R5 busy/", tag});
    chk({7'd0, ready}, {7'd0, !(m_busy && rst_n)}, {"R5 ready/", tag});
    if (m_rd_ok) chk(rd_data, m_rd, {"R10 read/", tag});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic issue(input logic [1:0] op, input int a, input logic [7:0] d, input logic wp);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = AW'(a); req_data = d; wp_n = wp;
    @(negedge clk);
    req_valid = 0; req_op = 2'b00; wp_n = 1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string r);
    @(negedge clk); rd_addr = AW'(a);
    @(negedge clk); #2;
    chk(rd_data, exp, r);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #2; chk({7'd0, busy}, 8'd0, "R1 busy in reset");
    chk({7'd0, ready}, 8'd1, "R1 ready in reset");
    rst_n = 1;
    @(negedge clk); #2;
    chk({7'd0, busy}, 8'd0, "R1 busy after reset");

    tag = "R3";
    issue(2'b10, 0, 8'h00, 1); wait_idle();
    rd(0, 8'hFF, "R3 chip erase byte 0");
    rd(63, 8'hFF, "R3 chip erase byte 63");
    rd(37, 8'hFF, "R3 chip erase byte 37");

    tag = "R4";
    issue(2'b11, 5, 8'hA5, 1);
    rd(5, 8'hFF, "R6 old value during busy");
    wait_idle();
    rd(5, 8'hA5, "R4 program erased byte");
    issue(2'b11, 5, 8'h0F, 1); wait_idle();
    rd(5, 8'h05, "R4 program ANDs into used byte");

    tag = "R2";
    issue(2'b11, 20, 8'h3C, 1); wait_idle();
    issue(2'b11, 40, 8'h00, 1); wait_idle();
    issue(2'b01, 17, 8'h00, 1); wait_idle();
    rd(20, 8'hFF, "R2 sector 1 erased");
    rd(16, 8'hFF, "R2 sector 1 low edge");
    rd(5, 8'h05, "R2 sector 0 untouched");
    rd(40, 8'h00, "R2 sector 2 untouched");

    tag = "R7";
    issue(2'b11, 6, 8'h00, 0);
    #2; chk({7'd0, busy}, 8'd0, "R7 protected request not started");
    rd(6, 8'hFF, "R7 protected byte unchanged");

    tag = "R8";
    issue(2'b01, 3, 8'h00, 1);
    issue(2'b11, 33, 8'h00, 1);
    wait_idle();
    rd(33, 8'hFF, "R8 request during busy ignored");
    rd(5, 8'hFF, "R8 first operation completed");

    tag = "R9";
    issue(2'b11, 7, 8'h11, 1);
    @(negedge clk); rst_n = 0; #1;
    chk({7'd0, busy}, 8'd0, "R9 reset drops busy");
    issue(2'b11, 7, 8'h11, 1);
    @(negedge clk); rst_n = 1;
    repeat (TB + 3) @(negedge clk);
    rd(7, 8'hFF, "R9 aborted byte untouched");

    tag = "R11";
    issue(2'b00, 8, 8'h00, 1);
    #2; chk({7'd0, busy}, 8'd0, "R11 code 00 not started");

    tag = "R5";
    issue(2'b11, 8, 8'h80, 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(8'(n), 8'(TB), "R5 program busy length");
    issue(2'b01, 50, 8'h00, 1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(8'(n), 8'(TS), "R5 sector erase busy length");
    rd(8, 8'h80, "R4 program result");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule